// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether an identifier taken off the CAN bus may enter the receive path. The identifier arrives as four bytes with a one-cycle valid strobe. The block compares those bytes with a bank of programmable acceptance-code bytes. Each code byte has its own mask byte, and a mask bit marks its identifier bit as don't-care.

A two-bit organization field sets how the bank is used. It can act as one wide filter, as two half-width filters, or as four single-byte filters. It can also close the filter so that nothing is accepted.

On acceptance, the block raises an accept pulse and a load strobe for the receive foreground buffer. It also records in a hit-index register which filter matched. The organization field and the hit index can be read back together in a control/status byte. The receive shifter and the buffer storage sit outside this block.

Top module: `can_id_accept_filter`

## Requirements
- R1: While `rst_n` is low at a clock edge, `accept`, `load_fg` and `hit_idx` clear to 0. With `filt_mode` at 0, `ctrl_rd` then reads 0.
- R2: A mask bit of 1 makes the matching identifier bit don't-care. A filter matches only when every identifier bit whose mask bit is 0 equals its code bit.
- R3: In organization 00 (wide), identifier byte k (`id_word[8k+7:8k]`, k = 0..3) is checked against code and mask byte k (`acc_code`/`acc_mask` bits `[8k+7:8k]`). The one filter reports hit index 0.
- R4: In organization 01 (half), identifier bytes 0 and 1 are checked twice. Filter 0 uses code/mask bytes 0 and 1. Filter 1 uses code/mask bytes 2 and 3. Identifier bytes 2 and 3 are ignored.
- R5: In organization 10 (byte), identifier byte 0 is checked against each of code/mask bytes 0..3 in turn. Filter n uses byte n.
- R6: In organization 11 (closed), no identifier is accepted, `load_fg` stays low, and `hit_idx` keeps its value.
- R7: When several filters match, the lowest-numbered one is reported in `hit_idx`.
- R8: `hit_idx` changes only in a cycle where `accept` is high. A rejected identifier leaves it unchanged.
- R9: `accept` and `load_fg` are high in the cycle after a cycle with `id_valid` high whose identifier matched. They are low otherwise. Back-to-back valid identifiers give back-to-back pulses.
- R10: `ctrl_rd` has `filt_mode` in bits 5:4 and `hit_idx` in bits 1:0. Bits 7:6 and 3:2 read 0.
- R11: Code and mask bytes 4..7 (`acc_code`/`acc_mask` bits 63:32) have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_valid | input | 1 | Identifier bytes valid this cycle |
| id_word | input | 32 | Identifier bytes, byte k at bits [8k+7:8k] |
| acc_code | input | 64 | Acceptance code bank, byte j at bits [8j+7:8j] |
| acc_mask | input | 64 | Acceptance mask bank, 1 = don't-care |
| filt_mode | input | 2 | Filter organization: 00 wide, 01 half, 10 byte, 11 closed |
| accept | output | 1 | Identifier accepted (one-cycle pulse) |
| load_fg | output | 1 | Load strobe for the receive foreground buffer |
| hit_idx | output | 2 | Index of the filter behind the last acceptance |
| ctrl_rd | output | 8 | Control/status byte: organization and hit index |

## Verification
The identifier, code, mask and organization are all sampled on the edge where `id_valid` is high. `accept`, `load_fg` and the updated `hit_idx` are therefore due exactly one cycle later. `ctrl_rd` follows the current `filt_mode` at once and follows the hit index from that same edge.

The bench drives one set of inputs on each falling edge. Its behavioural model pushes the expected outputs into a queue at that moment. The queue is popped and compared at the next falling edge, one rising edge later, so each result is checked in the cycle it is due.

// File: rtl/can_acf_pkg.sv
// Package: shared types and sizes for the CAN identifier acceptance filter.
// Assumes four identifier bytes and a two-bit organization field.
package can_acf_pkg;

    typedef enum logic [1:0] {
        ACF_WIDE   = 2'b00,
        ACF_HALF   = 2'b01,
        ACF_BYTE   = 2'b10,
        ACF_CLOSED = 2'b11
    } acf_mode_e;

    localparam int ACF_ID_BYTES = 4;
    localparam int ACF_BYTE_W   = 8;

endpackage

// File: rtl/can_acf_route.sv
// Module: picks which identifier byte feeds filter slot SLOT under the
// current organization. Assumes NBYTES is even (the half mode splits in two).
module can_acf_route
    import can_acf_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 4,
    parameter int SLOT   = 0,
    localparam int ID_W  = BYTE_W * NBYTES,
    localparam int HALF  = NBYTES / 2
) (
    input  logic [ID_W-1:0]   id_word,
    input  acf_mode_e         mode,
    output logic [BYTE_W-1:0] id_byte
);

    localparam int HALF_SRC = SLOT % HALF;

    // Select the identifier byte that this code/mask slot compares against.
    always_comb begin
        unique case (mode)
            ACF_HALF: id_byte = id_word[HALF_SRC*BYTE_W +: BYTE_W];
            ACF_BYTE: id_byte = id_word[0 +: BYTE_W];
            default:  id_byte = id_word[SLOT*BYTE_W +: BYTE_W];
        endcase
    end

endmodule

// File: rtl/can_acf_byte_cmp.sv
// Module: masked compare of one identifier byte with one code byte.
// A mask bit of 1 makes that bit position don't-care.
module can_acf_byte_cmp #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] id_byte,
    input  logic [BYTE_W-1:0] code_byte,
    input  logic [BYTE_W-1:0] mask_byte,
    output logic              byte_ok
);

    logic [BYTE_W-1:0] bit_ok;

    // Each bit passes when it agrees with the code or is masked out.
    always_comb begin
        bit_ok  = ~(id_byte ^ code_byte) | mask_byte;
        byte_ok = &bit_ok;
    end

endmodule

// File: rtl/can_acf_resolve.sv
// Module: groups the per-slot byte results into filters for the current
// organization and encodes the lowest-numbered matching filter.
// Assumes NBYTES is even and a power of two.
module can_acf_resolve
    import can_acf_pkg::*;
#(
    parameter int NBYTES = 4,
    localparam int HIT_W = $clog2(NBYTES),
    localparam int HALF  = NBYTES / 2
) (
    input  logic [NBYTES-1:0] slot_ok,
    input  acf_mode_e         mode,
    output logic              any_hit,
    output logic [HIT_W-1:0]  hit_num
);

    logic [NBYTES-1:0] filt_ok;

    // Form the match vector, one bit per filter, under the organization.
    always_comb begin
        filt_ok = '0;
        unique case (mode)
            ACF_WIDE: filt_ok[0] = &slot_ok;
            ACF_HALF: begin
                filt_ok[0] = &slot_ok[HALF-1:0];
                filt_ok[1] = &slot_ok[NBYTES-1:HALF];
            end
            ACF_BYTE: filt_ok = slot_ok;
            default:  filt_ok = '0;
        endcase
    end

    // Priority encode: scan from the top so the lowest matching index wins.
    always_comb begin
        any_hit = |filt_ok;
        hit_num = '0;
        for (int i = NBYTES - 1; i >= 0; i--) begin
            if (filt_ok[i]) hit_num = HIT_W'(i);
        end
    end

endmodule

// File: rtl/can_id_accept_filter.sv
// Module: CAN identifier acceptance filter, top level.
// Samples the identifier bytes, code/mask bank and organization on an edge
// where id_valid is high. It pulses accept/load_fg one cycle later and
// records the matching filter. Code/mask bytes above ID_BYTES are unused.
// Assumes ID_BYTES = 4 so that the hit index fits ctrl_rd[1:0].
module can_id_accept_filter
    import can_acf_pkg::*;
#(
    parameter int BYTE_W     = ACF_BYTE_W,
    parameter int ID_BYTES   = ACF_ID_BYTES,
    parameter int BANK_BYTES = 8,
    localparam int ID_W      = BYTE_W * ID_BYTES,
    localparam int BANK_W    = BYTE_W * BANK_BYTES,
    localparam int HIT_W     = $clog2(ID_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_valid,
    input  logic [ID_W-1:0]   id_word,
    input  logic [BANK_W-1:0] acc_code,
    input  logic [BANK_W-1:0] acc_mask,
    input  logic [1:0]        filt_mode,
    output logic              accept,
    output logic              load_fg,
    output logic [HIT_W-1:0]  hit_idx,
    output logic [7:0]        ctrl_rd
);

    acf_mode_e         mode;
    logic [ID_BYTES-1:0] slot_ok;
    logic              any_hit;
    logic [HIT_W-1:0]  hit_num;
    logic              accept_q;
    logic [HIT_W-1:0]  hit_q;
    logic              unused_bank_hi;

    assign mode = acf_mode_e'(filt_mode);

    // Upper bank bytes carry no function in any organization.
    assign unused_bank_hi = ^{acc_code[BANK_W-1:ID_W], acc_mask[BANK_W-1:ID_W]};

    for (genvar j = 0; j < ID_BYTES; j++) begin : g_slot
        logic [BYTE_W-1:0] sel_byte;

        can_acf_route #(
            .BYTE_W (BYTE_W),
            .NBYTES (ID_BYTES),
            .SLOT   (j)
        ) u_route (
            .id_word (id_word),
            .mode    (mode),
            .id_byte (sel_byte)
        );

        can_acf_byte_cmp #(
            .BYTE_W (BYTE_W)
        ) u_cmp (
            .id_byte   (sel_byte),
            .code_byte (acc_code[j*BYTE_W +: BYTE_W]),
            .mask_byte (acc_mask[j*BYTE_W +: BYTE_W]),
            .byte_ok   (slot_ok[j])
        );
    end

    can_acf_resolve #(
        .NBYTES (ID_BYTES)
    ) u_resolve (
        .slot_ok (slot_ok),
        .mode    (mode),
        .any_hit (any_hit),
        .hit_num (hit_num)
    );

    // Register the accept pulse and capture the hit index on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept_q <= 1'b0;
            hit_q    <= '0;
        end else begin
            accept_q <= id_valid && any_hit;
            if (id_valid && any_hit) hit_q <= hit_num;
        end
    end

    // Drive the outputs and the control/status byte layout.
    always_comb begin
        accept  = accept_q;
        load_fg = accept_q;
        hit_idx = hit_q;
        ctrl_rd = {2'b00, filt_mode, 2'b00, 2'(hit_q)};
    end

endmodule

// File: rtl/can_acf_chk.sv
// Module: assertion checker for can_id_accept_filter, attached by bind.
// Assumes the default four-byte identifier (two-bit hit index).
module can_acf_chk #(
    parameter int HIT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             id_valid,
    input logic [1:0]       filt_mode,
    input logic             accept,
    input logic             load_fg,
    input logic [HIT_W-1:0] hit_idx,
    input logic [7:0]       ctrl_rd
);

    assert_accept_after_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> $past(id_valid));

    assert_load_with_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_fg == accept);

    assert_closed_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> $past(filt_mode) != 2'b11);

    assert_hit_moves_on_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_idx != $past(hit_idx)) |-> accept);

    assert_wide_hit_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && $past(filt_mode) == 2'b00) |-> hit_idx == '0);

    assert_half_hit_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && $past(filt_mode) == 2'b01) |-> hit_idx <= HIT_W'(1));

    assert_ctrl_hit_field_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd[1:0] == 2'(hit_idx) && ctrl_rd[5:4] == filt_mode);

endmodule

bind can_id_accept_filter can_acf_chk #(
    .HIT_W (HIT_W)
) u_acf_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .id_valid  (id_valid),
    .filt_mode (filt_mode),
    .accept    (accept),
    .load_fg   (load_fg),
    .hit_idx   (hit_idx),
    .ctrl_rd   (ctrl_rd)
);

// File: tb/can_id_accept_filter_tb_top.sv
// Bench: drives on falling edges, keeps a behavioural model of the filter,
// and compares every output one clock after each stimulus.
module can_id_accept_filter_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        id_valid;
    logic [31:0] id_word;
    logic [63:0] acc_code;
    logic [63:0] acc_mask;
    logic [1:0]  filt_mode;
    logic        accept;
    logic        load_fg;
    logic [1:0]  hit_idx;
    logic [7:0]  ctrl_rd;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    int model_hit = 0;
    int exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    can_id_accept_filter dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .id_valid  (id_valid),
        .id_word   (id_word),
        .acc_code  (acc_code),
        .acc_mask  (acc_mask),
        .filt_mode (filt_mode),
        .accept    (accept),
        .load_fg   (load_fg),
        .hit_idx   (hit_idx),
        .ctrl_rd   (ctrl_rd)
    );

    // Behavioural filter: returns 1 on a match and the lowest matching filter.
    function automatic bit ref_match(input logic [1:0] md, input logic [31:0] id,
                                     input logic [63:0] c, input logic [63:0] m,
                                     output int h);
        int nf;
        int per;
        h = 0;
        case (md)
            2'b00: begin nf = 1; per = 4; end
            2'b01: begin nf = 2; per = 2; end
            2'b10: begin nf = 4; per = 1; end
            default: return 1'b0;
        endcase
        for (int f = 0; f < nf; f++) begin
            bit ok = 1'b1;
            for (int b = 0; b < per; b++) begin
                int cb = f * per + b;
                if (((id[8*b +: 8] ^ c[8*cb +: 8]) & ~m[8*cb +: 8]) != 8'h00) ok = 1'b0;
            end
            if (ok) begin
                h = f;
                return 1'b1;
            end
        end
        return 1'b0;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One cycle: drive at a falling edge, then compare at the next one.
    task automatic step(input logic v, input logic [31:0] id, input logic [1:0] md,
                        input string req);
        int h;
        int e_acc;
        id_valid  = v;
        id_word   = id;
        filt_mode = md;
        e_acc = (v && ref_match(md, id, acc_code, acc_mask, h)) ? 1 : 0;
        if (e_acc == 1) model_hit = h;
        exp_q.push_back(e_acc);
        @(negedge clk);
        e_acc = exp_q.pop_front();
        check(req, "accept", int'(accept), e_acc);
        check(req, "load_fg", int'(load_fg), e_acc);
        check(req, "hit_idx", int'(hit_idx), model_hit);
        check({req, " R10"}, "ctrl_rd", int'(ctrl_rd), int'({2'b00, md, 2'b00, 2'(model_hit)}));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; id_valid = 1'b1; id_word = 32'h0; filt_mode = 2'b00;
        acc_code = '0; acc_mask = '0;
        repeat (3) @(negedge clk);
        // R1: reset state, even with a matching valid identifier held.
        check("R1", "accept", int'(accept), 0);
        check("R1", "load_fg", int'(load_fg), 0);
        check("R1", "hit_idx", int'(hit_idx), 0);
        check("R1", "ctrl_rd", int'(ctrl_rd), 0);
        rst_n = 1'b1;
        id_valid = 1'b0;
        @(negedge clk);

        // R3: wide filter exact match, single mismatch, masked mismatch.
        acc_code = 64'hDEAD_BEEF_1234_5678;
        step(1, 32'h1234_5678, 2'b00, "R3");
        step(1, 32'h9234_5678, 2'b00, "R3");
        acc_mask = 64'h0000_0000_8000_0000;
        step(1, 32'h9234_5678, 2'b00, "R3");

        // R2: differences only in masked bits pass; unmasked bits reject.
        acc_mask = 64'h0000_0000_0000_000F;
        step(1, 32'h1234_567A, 2'b00, "R2");
        step(1, 32'h1234_5698, 2'b00, "R2");

        // R11: upper bank bytes changed, result unchanged.
        acc_code = 64'h0102_0304_1234_5678; acc_mask = 64'hFFFF_FFFF_0000_0000;
        step(1, 32'h1234_5678, 2'b00, "R11");
        acc_mask = 64'h0000_0000_0000_0000;
        step(1, 32'h1234_5678, 2'b00, "R11");

        // R4: half filters; identifier bytes 2 and 3 ignored.
        acc_code = 64'h0000_0000_ABCD_1234;
        step(1, 32'h0000_ABCD, 2'b01, "R4");
        step(1, 32'hFFFF_1234, 2'b01, "R4");
        step(1, 32'h1234_0000, 2'b01, "R4");

        // R5: byte filters on identifier byte 0.
        acc_code = 64'h0000_0000_4433_2211;
        step(1, 32'hA5A5_A533, 2'b10, "R5");
        step(1, 32'h0000_0044, 2'b10, "R5");

        // R7: filters 1 and 3 both match; lowest wins.
        acc_mask = 64'h0000_0000_0000_FF00;
        step(1, 32'h0000_0044, 2'b10, "R7");

        // R8: a reject keeps the previous hit index.
        acc_mask = '0;
        step(1, 32'h0000_0033, 2'b10, "R8");
        step(1, 32'h0000_0099, 2'b10, "R8");

        // R6: closed organization ignores a full don't-care bank.
        acc_mask = '1;
        step(1, 32'hFFFF_FFFF, 2'b11, "R6");
        step(1, 32'h0000_0000, 2'b11, "R6");

        // R9: no pulse without valid, back-to-back pulses with valid.
        step(0, 32'h0000_0000, 2'b00, "R9");
        step(1, 32'h0000_0000, 2'b00, "R9");
        step(1, 32'h1111_1111, 2'b10, "R9");
        step(0, 32'h1111_1111, 2'b10, "R9");

        // Mixed traffic across all organizations.
        for (int i = 0; i < 400; i++) begin
            logic [1:0]  md = 2'($urandom_range(0, 3));
            logic [31:0] id;
            acc_code = {$urandom, $urandom};
            acc_mask = {$urandom, $urandom & $urandom & $urandom};
            id = acc_code[31:0];
            if ($urandom_range(0, 3) == 0) id = id ^ (32'h1 << $urandom_range(0, 31));
            if (md == 2'b10) id[7:0] = acc_code[8*$urandom_range(0, 3) +: 8];
            if (md == 2'b01 && $urandom_range(0, 1) == 1) id[15:0] = acc_code[31:16];
            step(1'($urandom_range(0, 4) != 0), id, md, "R2 R3 R4 R5 R7 R8");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule